// File: doc/BRIEF.md
# Serial Calendar Access Port

This block is the serial slave that sits between a four-wire host link and a calendar counter. The host drives a chip enable, a serial clock and a direction pin. It exchanges bits over one shared data wire, which appears here as a data input, a data output and an output enable. A level on the direction pin chooses the access type. It must be settled before chip enable rises, and the serial clock must be low at both chip-enable edges. Every pin is resampled into the system clock domain through a synchronizer chain, so each pin event takes effect a fixed few system cycles after it happens.

When the direction pin is low (read), the rising edge of chip enable copies the whole calendar into a shift register, and the first bit is driven at once. Each falling serial-clock edge then advances the stream by one bit. When the direction pin is high (write), the rising edge of chip enable clears the register, and each rising serial-clock edge shifts the data wire in. The falling edge of chip enable hands the register contents to the counter. While a write access is open, a hold line tells the counter to freeze and clear its prescaler. A low-battery flag replaces every 4-bit digit of a read snapshot with hex E.

The committed time leaves as a valid/ready stream. `wr_valid_o` rises one cycle after chip enable falls in write mode and stays high until a cycle with `wr_ready_i` high. While it waits, the payload stays stable. A newer commit that arrives before the handshake completes replaces the waiting payload, so the counter always receives the most recent write.

Top module: `rtc_serial_port`

## Requirements
- R1: `sdata_oe_o` is high only while chip enable is high and the direction pin is low (0 = read, 1 = write). With chip enable low it is low whatever the direction pin is, and `sdata_o` is then 0.
- R2: In read mode the calendar inputs are copied when chip enable rises, and bit 0 is driven without any serial-clock edge. Input changes after that edge do not alter the stream.
- R3: In read mode each falling serial-clock edge advances the stream by one bit. Once the valid bits are used up, the data output reads 0.
- R4: The full-calendar read stream (FULL_CAL=1) carries 52 bits, each field LSB first, in this bit order: year 0-7, month 8-15, date 16-23, day of week 24-27, hour 28-35, minute 36-43, second 44-51.
- R5: With `low_batt_i` high at the chip-enable rise, every 4-bit digit of the snapshot is 4'hE, so each nibble arrives as 0,1,1,1.
- R6: In write mode the data input is sampled on each rising serial-clock edge. When chip enable falls, the last 44 bits clocked in (FULL_CAL=1) become the payload: year 0-7, month 8-15, date 16-23, day 24-27, hour 28-35, minute 36-43, counted from the oldest kept bit. Earlier bits are dropped, and seconds are never written.
- R7: A write with fewer bits than the payload width still commits. The received bits occupy the top of the payload in arrival order, and the bits below them are zero.
- R8: `hold_o` is high while chip enable and the direction pin are both high, and it goes low when chip enable falls.
- R9: Serial-clock edges while chip enable is low change nothing. No commit occurs and the data output stays disabled.
- R10: `wr_valid_o` holds with a stable payload until a cycle with `wr_ready_i` high, then falls. A commit that arrives while one is pending replaces its payload.
- R11: The reduced variant (FULL_CAL=0) reads 28 bits: day of week 0-3, hour 4-11, minute 12-19, second 20-27. It writes the last 20 bits: day 0-3, hour 4-11, minute 12-19. It reports year, month and date as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable from the host |
| sclk_i | input | 1 | Serial clock from the host |
| dir_i | input | 1 | Access direction, 1 = write, 0 = read |
| sdata_i | input | 1 | Data wire, incoming level |
| sdata_o | output | 1 | Data wire, outgoing level |
| sdata_oe_o | output | 1 | Data wire output enable |
| low_batt_i | input | 1 | Low-battery flag |
| tm_year_i | input | FIELD_W | Current year, BCD |
| tm_month_i | input | FIELD_W | Current month, BCD |
| tm_date_i | input | FIELD_W | Current date, BCD |
| tm_dow_i | input | DOW_W | Current day of week |
| tm_hour_i | input | FIELD_W | Current hour, BCD |
| tm_min_i | input | FIELD_W | Current minute, BCD |
| tm_sec_i | input | FIELD_W | Current second, BCD |
| hold_o | output | 1 | Freeze counter and clear prescaler |
| wr_valid_o | output | 1 | Committed time waiting |
| wr_ready_i | input | 1 | Counter accepts committed time |
| wr_year_o | output | FIELD_W | Committed year |
| wr_month_o | output | FIELD_W | Committed month |
| wr_date_o | output | FIELD_W | Committed date |
| wr_dow_o | output | DOW_W | Committed day of week |
| wr_hour_o | output | FIELD_W | Committed hour |
| wr_min_o | output | FIELD_W | Committed minute |

## Verification
Reads are swept over 24 calendar settings, chosen so that every field holds a different value with mixed bit patterns. A swapped field, a reversed bit order or an off-by-one shift therefore shows up as a mismatch in that field, not in the stream as a whole. Writes are swept with 0 to 18 leading junk bits in front of a 44-bit payload, which tells a design that keeps the last bits apart from one that keeps the first. A short write with 10 bits shows whether the received bits land at the top of the payload with zero fill below. Full and reduced instances take the same pin traffic side by side, so the two stream layouts are told apart on one stimulus. Separate runs cover the low-battery pattern, changes to the calendar inputs after the snapshot, idle clocking and a held-off ready.

// File: rtl/rtc_sio_pkg.sv
package rtc_sio_pkg;

  typedef enum logic [1:0] {
    SIO_IDLE  = 2'd0,
    SIO_READ  = 2'd1,
    SIO_WRITE = 2'd2
  } sio_mode_e;

  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] LOWBATT_DIGIT = 4'hE;

  function automatic int unsigned sio_rd_bits(bit full, int unsigned fw, int unsigned dw);
    return full ? (6 * fw + dw) : (3 * fw + dw);
  endfunction

  function automatic int unsigned sio_wr_bits(bit full, int unsigned fw, int unsigned dw);
    return sio_rd_bits(full, fw, dw) - fw;
  endfunction

endpackage

// File: rtl/rtc_sio_sync.sv
module rtc_sio_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '0;
          else        r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '0;
          else        r <= g_stage[s-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/rtc_sio_ctrl.sv
module rtc_sio_ctrl
  import rtc_sio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_s,
  input  logic sclk_s,
  input  logic dir_s,
  output logic load_rd,
  output logic start_wr,
  output logic shift_out,
  output logic shift_in,
  output logic commit_evt,
  output logic oe_q,
  output logic hold_q
);

  sio_mode_e mode_q;
  logic      ce_p, sclk_p;
  logic      ce_rise, ce_fall, sclk_rise, sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_p   <= 1'b0;
      sclk_p <= 1'b0;
    end else begin
      ce_p   <= ce_s;
      sclk_p <= sclk_s;
    end
  end

  assign ce_rise   =  ce_s   & ~ce_p;
  assign ce_fall   = ~ce_s   &  ce_p;
  assign sclk_rise =  sclk_s & ~sclk_p;
  assign sclk_fall = ~sclk_s &  sclk_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SIO_IDLE;
    end else begin
      unique case (mode_q)
        SIO_IDLE:  if (ce_rise) mode_q <= dir_s ? SIO_WRITE : SIO_READ;
        SIO_READ,
        SIO_WRITE: if (ce_fall) mode_q <= SIO_IDLE;
        default:   mode_q <= SIO_IDLE;
      endcase
    end
  end

  // Edge events; serial clock edges count only inside an open access
  assign load_rd    = (mode_q == SIO_IDLE)  & ce_rise & ~dir_s;
  assign start_wr   = (mode_q == SIO_IDLE)  & ce_rise &  dir_s;
  assign shift_out  = (mode_q == SIO_READ)  & ce_s & sclk_fall;
  assign shift_in   = (mode_q == SIO_WRITE) & ce_s & sclk_rise;
  assign commit_evt = (mode_q == SIO_WRITE) & ce_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      oe_q   <= ce_s & ~dir_s;
      hold_q <= ce_s &  dir_s;
    end
  end

endmodule

// File: rtl/rtc_sio_shreg.sv
module rtc_sio_shreg
  import rtc_sio_pkg::*;
#(
  parameter bit          FULL_CAL = 1'b1,
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned DOW_W    = 4,
  parameter int unsigned RD_W     = 52,
  parameter int unsigned WR_W     = 44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_rd,
  input  logic               start_wr,
  input  logic               shift_out,
  input  logic               shift_in,
  input  logic               din,
  input  logic               low_batt,
  input  logic [FIELD_W-1:0] year,
  input  logic [FIELD_W-1:0] month,
  input  logic [FIELD_W-1:0] date,
  input  logic [DOW_W-1:0]   dow,
  input  logic [FIELD_W-1:0] hour,
  input  logic [FIELD_W-1:0] minute,
  input  logic [FIELD_W-1:0] second,
  output logic               dout,
  output logic [WR_W-1:0]    wr_word
);

  localparam int unsigned NDIG = RD_W / DIGIT_W;

  logic [RD_W-1:0] snap_raw, snap, sr_q;

  generate
    if (FULL_CAL) begin : g_full
      assign snap_raw = {second, minute, hour, dow, date, month, year};
    end else begin : g_short
      assign snap_raw = {second, minute, hour, dow};
    end

    for (genvar d = 0; d < NDIG; d++) begin : g_digit
      assign snap[d*DIGIT_W +: DIGIT_W] = low_batt ? LOWBATT_DIGIT
                                                   : snap_raw[d*DIGIT_W +: DIGIT_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_rd) begin
      sr_q <= snap;
    end else if (start_wr) begin
      sr_q <= '0;
    end else if (shift_out) begin
      sr_q <= {1'b0, sr_q[RD_W-1:1]};
    end else if (shift_in) begin
      sr_q[WR_W-1:0] <= {din, sr_q[WR_W-1:1]};
    end
  end

  assign dout    = sr_q[0];
  assign wr_word = sr_q[WR_W-1:0];

endmodule

// File: rtl/rtc_sio_commit.sv
module rtc_sio_commit #(
  parameter bit          FULL_CAL = 1'b1,
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned DOW_W    = 4,
  parameter int unsigned WR_W     = 44
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_evt,
  input  logic [WR_W-1:0]    word,
  input  logic               ready,
  output logic               valid,
  output logic [FIELD_W-1:0] year,
  output logic [FIELD_W-1:0] month,
  output logic [FIELD_W-1:0] date,
  output logic [DOW_W-1:0]   dow,
  output logic [FIELD_W-1:0] hour,
  output logic [FIELD_W-1:0] minute
);

  localparam int unsigned DOW_LSB  = FULL_CAL ? 3 * FIELD_W : 0;
  localparam int unsigned HOUR_LSB = DOW_LSB + DOW_W;
  localparam int unsigned MIN_LSB  = HOUR_LSB + FIELD_W;

  logic [WR_W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      held_q <= '0;
    end else if (commit_evt) begin
      valid  <= 1'b1;
      held_q <= word;
    end else if (valid && ready) begin
      valid  <= 1'b0;
    end
  end

  assign dow    = held_q[DOW_LSB  +: DOW_W];
  assign hour   = held_q[HOUR_LSB +: FIELD_W];
  assign minute = held_q[MIN_LSB  +: FIELD_W];

  generate
    if (FULL_CAL) begin : g_full
      assign year  = held_q[0         +: FIELD_W];
      assign month = held_q[FIELD_W   +: FIELD_W];
      assign date  = held_q[2*FIELD_W +: FIELD_W];
    end else begin : g_short
      assign year  = '0;
      assign month = '0;
      assign date  = '0;
    end
  endgenerate

endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rtc_sio_pkg::*;
#(
  parameter bit          FULL_CAL    = 1'b1,
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned DOW_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_i,
  input  logic               sclk_i,
  input  logic               dir_i,
  input  logic               sdata_i,
  output logic               sdata_o,
  output logic               sdata_oe_o,
  input  logic               low_batt_i,
  input  logic [FIELD_W-1:0] tm_year_i,
  input  logic [FIELD_W-1:0] tm_month_i,
  input  logic [FIELD_W-1:0] tm_date_i,
  input  logic [DOW_W-1:0]   tm_dow_i,
  input  logic [FIELD_W-1:0] tm_hour_i,
  input  logic [FIELD_W-1:0] tm_min_i,
  input  logic [FIELD_W-1:0] tm_sec_i,
  output logic               hold_o,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [FIELD_W-1:0] wr_year_o,
  output logic [FIELD_W-1:0] wr_month_o,
  output logic [FIELD_W-1:0] wr_date_o,
  output logic [DOW_W-1:0]   wr_dow_o,
  output logic [FIELD_W-1:0] wr_hour_o,
  output logic [FIELD_W-1:0] wr_min_o
);

  localparam int unsigned RD_W = sio_rd_bits(FULL_CAL, FIELD_W, DOW_W);
  localparam int unsigned WR_W = sio_wr_bits(FULL_CAL, FIELD_W, DOW_W);

  logic            ce_s, sclk_s, dir_s, din_s;
  logic            load_rd, start_wr, shift_out, shift_in, commit_evt;
  logic            oe_q, dout;
  logic [WR_W-1:0] wr_word;

  rtc_sio_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ce_i, sclk_i, dir_i, sdata_i}),
    .q     ({ce_s, sclk_s, dir_s, din_s})
  );

  rtc_sio_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_s       (ce_s),
    .sclk_s     (sclk_s),
    .dir_s      (dir_s),
    .load_rd    (load_rd),
    .start_wr   (start_wr),
    .shift_out  (shift_out),
    .shift_in   (shift_in),
    .commit_evt (commit_evt),
    .oe_q       (oe_q),
    .hold_q     (hold_o)
  );

  rtc_sio_shreg #(
    .FULL_CAL (FULL_CAL), .FIELD_W (FIELD_W), .DOW_W (DOW_W),
    .RD_W     (RD_W),     .WR_W    (WR_W)
  ) u_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_rd   (load_rd),
    .start_wr  (start_wr),
    .shift_out (shift_out),
    .shift_in  (shift_in),
    .din       (din_s),
    .low_batt  (low_batt_i),
    .year      (tm_year_i),
    .month     (tm_month_i),
    .date      (tm_date_i),
    .dow       (tm_dow_i),
    .hour      (tm_hour_i),
    .minute    (tm_min_i),
    .second    (tm_sec_i),
    .dout      (dout),
    .wr_word   (wr_word)
  );

  rtc_sio_commit #(
    .FULL_CAL (FULL_CAL), .FIELD_W (FIELD_W), .DOW_W (DOW_W), .WR_W (WR_W)
  ) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_evt (commit_evt),
    .word       (wr_word),
    .ready      (wr_ready_i),
    .valid      (wr_valid_o),
    .year       (wr_year_o),
    .month      (wr_month_o),
    .date       (wr_date_o),
    .dow        (wr_dow_o),
    .hour       (wr_hour_o),
    .minute     (wr_min_o)
  );

  assign sdata_oe_o = oe_q;
  assign sdata_o    = oe_q & dout;

endmodule

// File: rtl/rtc_serial_port_chk.sv
module rtc_serial_port_chk #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned DOW_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ce_s,
  input logic               dir_s,
  input logic               commit_evt,
  input logic               sdata_oe_o,
  input logic               hold_o,
  input logic               wr_valid_o,
  input logic               wr_ready_i,
  input logic [5*FIELD_W+DOW_W-1:0] payload
);

  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !sdata_oe_o);

  assert_oe_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && !dir_s) |=> sdata_oe_o);

  assert_hold_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && dir_s) |=> hold_o);

  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !hold_o);

  assert_commit_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> (!hold_o && $past(!ce_s)));

  assert_valid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o);

  assert_payload_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i && !commit_evt) |=> $stable(payload));

  assert_valid_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && !commit_evt) |=> !wr_valid_o);

endmodule

bind rtc_serial_port rtc_serial_port_chk #(.FIELD_W(FIELD_W), .DOW_W(DOW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_s       (ce_s),
  .dir_s      (dir_s),
  .commit_evt (commit_evt),
  .sdata_oe_o (sdata_oe_o),
  .hold_o     (hold_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .payload    ({wr_min_o, wr_hour_o, wr_dow_o, wr_date_o, wr_month_o, wr_year_o})
);

// File: tb/tb_rtc_serial_port.sv
module tb_rtc_serial_port;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ce, sclk, dir, sdi, lowb, rdy;
  logic [7:0] ty, tmo, tda, tho, tmi, tse;
  logic [3:0] tdw;

  logic sdo_f, oe_f, hold_f, val_f;
  logic sdo_r, oe_r, hold_r, val_r;
  logic [7:0] wy_f, wmo_f, wda_f, wh_f, wmi_f, wy_r, wmo_r, wda_r, wh_r, wmi_r;
  logic [3:0] wdw_f, wdw_r;

  int checks = 0;
  int fails  = 0;

  rtc_serial_port #(.FULL_CAL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .dir_i(dir), .sdata_i(sdi),
    .sdata_o(sdo_f), .sdata_oe_o(oe_f), .low_batt_i(lowb),
    .tm_year_i(ty), .tm_month_i(tmo), .tm_date_i(tda), .tm_dow_i(tdw),
    .tm_hour_i(tho), .tm_min_i(tmi), .tm_sec_i(tse),
    .hold_o(hold_f), .wr_valid_o(val_f), .wr_ready_i(rdy),
    .wr_year_o(wy_f), .wr_month_o(wmo_f), .wr_date_o(wda_f), .wr_dow_o(wdw_f),
    .wr_hour_o(wh_f), .wr_min_o(wmi_f)
  );

  rtc_serial_port #(.FULL_CAL(1'b0)) dut_r (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .dir_i(dir), .sdata_i(sdi),
    .sdata_o(sdo_r), .sdata_oe_o(oe_r), .low_batt_i(lowb),
    .tm_year_i(ty), .tm_month_i(tmo), .tm_date_i(tda), .tm_dow_i(tdw),
    .tm_hour_i(tho), .tm_min_i(tmi), .tm_sec_i(tse),
    .hold_o(hold_r), .wr_valid_o(val_r), .wr_ready_i(rdy),
    .wr_year_o(wy_r), .wr_month_o(wmo_r), .wr_date_o(wda_r), .wr_dow_o(wdw_r),
    .wr_hour_o(wh_r), .wr_min_o(wmi_r)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic void set_time(input int i);
    ty  = bcd((i * 7 + 3) % 100);
    tmo = bcd(i % 12 + 1);
    tda = bcd((i * 5) % 28 + 1);
    tdw = 4'(i % 7);
    tho = bcd(i % 24);
    tmi = bcd((i * 13 + 1) % 60);
    tse = bcd((i * 29 + 5) % 60);
  endfunction

  // Expected payload: last w bits of an n-bit stream, oldest kept bit at bit 0
  function automatic logic [43:0] exp_wr(input logic [63:0] bits, input int n, input int w);
    logic [43:0] res = '0;
    for (int i = 0; i < n; i++)
      if (i >= n - w) res[w - 1 - (n - 1 - i)] = bits[i];
    return res;
  endfunction

  task automatic do_read(input bit perturb, output logic [51:0] gf, output logic [27:0] gr,
                         output logic tailf, output logic tailr);
    dir = 1'b0; sdi = 1'b0; step();
    ce = 1'b1; step();
    if (perturb) set_time(77);
    for (int i = 0; i < 52; i++) begin
      if (i > 0) begin sclk = 1'b1; step(); sclk = 1'b0; step(); end
      gf[i] = sdo_f;
      if (i < 28) gr[i] = sdo_r;
    end
    sclk = 1'b1; step(); sclk = 1'b0; step();
    tailf = sdo_f; tailr = sdo_r;
    ce = 1'b0; step();
  endtask

  task automatic do_write(input logic [63:0] bits, input int n);
    dir = 1'b1; step();
    ce = 1'b1; step();
    for (int i = 0; i < n; i++) begin
      sdi = bits[i]; step();
      sclk = 1'b1; step();
      sclk = 1'b0; step();
    end
    ce = 1'b0; step();
    dir = 1'b0; sdi = 1'b0;
  endtask

  task automatic release_commit();
    rdy = 1'b1; @(negedge clk);
    rdy = 1'b0; @(negedge clk);
    chk("R10", "valid drops after ready (full)", 64'(val_f), 64'd0);
    chk("R10", "valid drops after ready (reduced)", 64'(val_r), 64'd0);
  endtask

  task automatic chk_payload(input string req, input logic [63:0] bits, input int n);
    logic [43:0] ef, er;
    ef = exp_wr(bits, n, 44);
    er = exp_wr(bits, n, 20);
    chk(req, "full valid", 64'(val_f), 64'd1);
    chk(req, "reduced valid", 64'(val_r), 64'd1);
    chk(req, "full payload", 64'({wmi_f, wh_f, wdw_f, wda_f, wmo_f, wy_f}), 64'(ef));
    chk("R11", "reduced payload", 64'({wmi_r, wh_r, wdw_r}), 64'(er[19:0]));
    chk("R11", "reduced year/month/date zero", 64'({wda_r, wmo_r, wy_r}), 64'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [51:0] gf;
    logic [27:0] gr;
    logic        tf, tr;
    logic [63:0] bits;

    rst_n = 1'b0; ce = 0; sclk = 0; dir = 0; sdi = 0; lowb = 0; rdy = 0;
    set_time(0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    step();

    // Reset state
    chk("R1", "oe after reset", 64'(oe_f), 64'd0);
    chk("R1", "data after reset", 64'(sdo_f), 64'd0);
    chk("R8", "hold after reset", 64'(hold_f), 64'd0);
    chk("R10", "valid after reset", 64'(val_f | val_r), 64'd0);

    // Read sweep over 24 calendar settings: R2 R3 R4 R11
    for (int i = 0; i < 24; i++) begin
      set_time(i);
      do_read(1'b0, gf, gr, tf, tr);
      chk("R4", "full read stream", 64'(gf), 64'({tse, tmi, tho, tdw, tda, tmo, ty}));
      chk("R11", "reduced read stream", 64'(gr), 64'({tse, tmi, tho, tdw}));
      chk("R3", "full tail zero", 64'(tf), 64'd0);
      chk("R3", "reduced tail zero", 64'(tr), 64'd0);
    end

    // R1: enable levels during read and write
    dir = 1'b0; step(); ce = 1'b1; step();
    chk("R1", "oe in read", 64'(oe_f), 64'd1);
    chk("R2", "first bit before any clock", 64'(sdo_f), 64'(ty[0]));
    chk("R8", "no hold in read", 64'(hold_f), 64'd0);
    ce = 1'b0; step();
    chk("R1", "oe after read", 64'(oe_f), 64'd0);

    // R2: inputs changed after the snapshot do not alter the stream
    set_time(5);
    bits = 64'({tse, tmi, tho, tdw, tda, tmo, ty});
    do_read(1'b1, gf, gr, tf, tr);
    chk("R2", "snapshot frozen at ce rise", 64'(gf), bits);

    // R5: low battery
    lowb = 1'b1;
    do_read(1'b0, gf, gr, tf, tr);
    chk("R5", "full low-battery stream", 64'(gf), 64'({13{4'hE}}));
    chk("R5", "reduced low-battery stream", 64'(gr), 64'({7{4'hE}}));
    lowb = 1'b0;

    // R8 and R7: empty write holds the counter and commits zero
    dir = 1'b1; step(); ce = 1'b1; step();
    chk("R8", "hold in write", 64'(hold_f), 64'd1);
    chk("R1", "oe off in write", 64'(oe_f), 64'd0);
    ce = 1'b0; step();
    chk("R8", "hold released", 64'(hold_f), 64'd0);
    dir = 1'b0;
    chk_payload("R7", 64'd0, 0);
    release_commit();

    // R6 write sweep with leading junk bits
    for (int j = 0; j < 10; j++) begin
      logic [43:0] pay;
      int k;
      k   = 2 * j;
      pay = {bcd((j * 11 + 7) % 60), bcd((j * 5 + 2) % 24), 4'((j + 3) % 7),
             bcd(j * 3 % 28 + 1), bcd(j % 12 + 1), bcd((j * 9 + 4) % 100)};
      bits = (64'(pay) << k) | (64'h5A5A5 & ((64'd1 << k) - 1));
      do_write(bits, k + 44);
      chk_payload("R6", bits, k + 44);
      chk("R6", "payload equals last 44 bits", 64'({wmi_f, wh_f, wdw_f, wda_f, wmo_f, wy_f}), 64'(pay));
      release_commit();
    end

    // R7: short write, bits at the top with zero fill
    bits = 64'h2D3;
    do_write(bits, 10);
    chk_payload("R7", bits, 10);
    chk("R7", "short write top bits", 64'({wmi_f, wh_f, wdw_f, wda_f, wmo_f, wy_f}), 64'(44'h2D3) << 34);
    release_commit();

    // R9: serial clocks with ce low
    dir = 1'b1; sdi = 1'b1;
    for (int p = 0; p < 10; p++) begin sclk = 1'b1; step(); sclk = 1'b0; step(); end
    chk("R9", "no commit from idle clocks", 64'(val_f | val_r), 64'd0);
    chk("R9", "output stays off", 64'(oe_f | sdo_f), 64'd0);
    chk("R9", "no hold from idle clocks", 64'(hold_f), 64'd0);
    dir = 1'b0; sdi = 1'b0; step();

    // R10: back-pressure and replacement
    bits = 64'hABCDE12345;
    do_write(bits, 44);
    repeat (20) @(negedge clk);
    chk_payload("R10", bits, 44);
    bits = 64'h0F1E2D3C4B5;
    do_write(bits, 44);
    chk_payload("R10", bits, 44);
    release_commit();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule